// File: doc/BRIEF.md
# Bidirectional Pass-Through Fault Injector

This block is placed in series on a single-wire (or narrow) bidirectional serial line and splits it into two separate segments, one toward agent A and one toward agent B. The agents never share a net. Each segment is modelled with split signals: the value the agent puts on its segment, a flag telling whether the agent is driving, and, in the other direction, the value and output enable the block presents to that agent. On every rising clock edge the block decides which agent owns the line, copies the owner's value to the opposite segment and leaves the owner's own segment undriven. When nobody drives, both segments are released.

Faults are injected by rewriting the forwarded value rather than by adding a third driver to a shared net, so a glitch lands cleanly even while an agent is actively driving. With the inject input high, the receiving side sees all zeros, or the inverted data when the invert configuration input is set. The driving agent still reads back its own value and cannot spot the fault locally. On an idle line an injected glitch drives zero onto both segments.

All outputs are registered, so every result appears one rising edge after the inputs that caused it. The reset is synchronous and active high.

Top module: `bidir_fault_injector`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are: `dir_status`=00, both output enables low, both output values zero, `contention` low; this holds even with an agent driving.
- R2: If only A drives, one edge later `dir_status`=01, `b_oe`=1, `b_out` equals the sampled `a_in`, and `a_oe`=0.
- R3: If only B drives, one edge later `dir_status`=10, `a_oe`=1, `a_out` equals the sampled `b_in`, and `b_oe`=0.
- R4: If neither agent drives and `inject_en` is low, one edge later `dir_status`=00 and both output enables and both output values are zero.
- R5: If both agents drive in the same cycle, the previous `dir_status` is kept (an idle line stays idle), the non-owner's data is not forwarded, and `contention` is high for that one following cycle; it is low after any cycle without dual drive.
- R6: With `inject_en` high and `invert_mode` low while an agent owns the line, the receiving side's output value is all zeros.
- R7: During a glitch the owner's segment keeps its output enable low and its output value equal to the owner's own sampled input.
- R8: With `inject_en` and `invert_mode` both high while an agent owns the line, the receiving side's output value is the bitwise inverse of the owner's sampled input.
- R9: With `inject_en` high on an idle line (neither agent driving), both output enables are high and both output values are zero, regardless of `invert_mode`.
- R10: Ownership hands over in one edge: if the owner stops and the other agent drives alone in the same cycle, the direction switches directly without passing through idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inject_en | input | 1 | Glitch request, sampled at each rising edge |
| invert_mode | input | 1 | Static: 1 inverts forwarded data during a glitch, 0 forces zero |
| a_in | input | W | Value agent A places on its segment |
| a_drv | input | 1 | Agent A is driving its segment |
| a_out | output | W | Value presented to agent A |
| a_oe | output | 1 | Block drives A's segment |
| b_in | input | W | Value agent B places on its segment |
| b_drv | input | 1 | Agent B is driving its segment |
| b_out | output | W | Value presented to agent B |
| b_oe | output | 1 | Block drives B's segment |
| dir_status | output | 2 | 00 idle, 01 A to B, 10 B to A |
| contention | output | 1 | Both agents drove in the previous cycle |

## Verification
Every output of this block is due exactly one rising edge after the inputs that produce it, since direction, forwarded data, enables and the contention flag all leave through a single register stage. The bench changes inputs on the falling edge and samples all outputs on the following falling edge, so exactly one rising edge separates each stimulus from its check. Because ownership depends on the previous direction, the vector table is ordered so each row starts from the state left by the row before it, and the contention and hand-over rows are placed right after a known owner has been set up.

// File: rtl/fi_pkg.sv
package fi_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_A2B  = 2'b01,
    DIR_B2A  = 2'b10
  } dir_e;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_A    = 0;
  localparam int SIDE_B    = 1;

endpackage

// File: rtl/fi_dir_arbiter.sv
module fi_dir_arbiter
  import fi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_drv,
  input  logic b_drv,
  output dir_e dir_n,
  output dir_e dir_q,
  output logic clash_q
);

  // Next owner: a lone driver wins; a simultaneous pair leaves ownership as is.
  always_comb begin
    if (a_drv && b_drv) begin
      dir_n = dir_q;
    end else if (a_drv) begin
      dir_n = DIR_A2B;
    end else if (b_drv) begin
      dir_n = DIR_B2A;
    end else begin
      dir_n = DIR_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= DIR_IDLE;
      clash_q <= 1'b0;
    end else begin
      dir_q   <= dir_n;
      clash_q <= a_drv && b_drv;
    end
  end

endmodule

// File: rtl/fi_fault_shaper.sv
module fi_fault_shaper #(
  parameter int W = 1
) (
  input  logic [W-1:0] src,
  input  logic         inject,
  input  logic         invert,
  output logic [W-1:0] fwd
);

  always_comb begin
    if (!inject) begin
      fwd = src;
    end else if (invert) begin
      fwd = ~src;
    end else begin
      fwd = '0;
    end
  end

endmodule

// File: rtl/fi_side_stage.sv
module fi_side_stage #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drive,
  input  logic [W-1:0] drive_val,
  input  logic [W-1:0] rb_val,
  output logic [W-1:0] out_q,
  output logic         oe_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= drive ? drive_val : rb_val;
      oe_q  <= drive;
    end
  end

endmodule

// File: rtl/bidir_fault_injector.sv
module bidir_fault_injector
  import fi_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inject_en,
  input  logic         invert_mode,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_drv,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [1:0]   dir_status,
  output logic         contention
);

  dir_e dir_n;
  dir_e dir_q;

  logic [W-1:0] side_in    [NUM_SIDES];
  logic [W-1:0] side_fwd   [NUM_SIDES];
  logic [W-1:0] side_val   [NUM_SIDES];
  logic [W-1:0] side_rb    [NUM_SIDES];
  logic         side_drive [NUM_SIDES];
  logic [W-1:0] side_out   [NUM_SIDES];
  logic         side_oe    [NUM_SIDES];

  assign side_in[SIDE_A] = a_in;
  assign side_in[SIDE_B] = b_in;

  fi_dir_arbiter u_arb (
    .clk     (clk),
    .rst     (rst),
    .a_drv   (a_drv),
    .b_drv   (b_drv),
    .dir_n   (dir_n),
    .dir_q   (dir_q),
    .clash_q (contention)
  );

  // One shaper per receiving side; it rewrites the peer's data.
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int PEER = NUM_SIDES - 1 - s;

    fi_fault_shaper #(.W(W)) u_shape (
      .src    (side_in[PEER]),
      .inject (inject_en),
      .invert (invert_mode),
      .fwd    (side_fwd[s])
    );

    fi_side_stage #(.W(W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .drive     (side_drive[s]),
      .drive_val (side_val[s]),
      .rb_val    (side_rb[s]),
      .out_q     (side_out[s]),
      .oe_q      (side_oe[s])
    );
  end

  always_comb begin
    for (int s = 0; s < NUM_SIDES; s++) begin
      side_drive[s] = 1'b0;
      side_val[s]   = '0;
      side_rb[s]    = '0;
    end
    unique case (dir_n)
      DIR_A2B: begin
        side_drive[SIDE_B] = 1'b1;
        side_val[SIDE_B]   = side_fwd[SIDE_B];
        side_rb[SIDE_A]    = a_in;
      end
      DIR_B2A: begin
        side_drive[SIDE_A] = 1'b1;
        side_val[SIDE_A]   = side_fwd[SIDE_A];
        side_rb[SIDE_B]    = b_in;
      end
      default: begin
        // Idle line: a glitch pulls both segments low.
        side_drive[SIDE_A] = inject_en;
        side_drive[SIDE_B] = inject_en;
      end
    endcase
  end

  assign a_out      = side_out[SIDE_A];
  assign a_oe       = side_oe[SIDE_A];
  assign b_out      = side_out[SIDE_B];
  assign b_oe       = side_oe[SIDE_B];
  assign dir_status = dir_q;

endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int W = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         inject_en,
  input logic         invert_mode,
  input logic [W-1:0] a_in,
  input logic         a_drv,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic         b_drv,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [1:0]   dir_status,
  input logic         contention
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (dir_status == 2'b00 && !a_oe && !b_oe && !contention)) else $error("reset"); // R1

  AST_A_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (a_drv && !b_drv && !inject_en) |=> (dir_status == 2'b01 && b_oe && !a_oe && b_out == $past(a_in))) else $error("a fwd"); // R2

  AST_B_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (b_drv && !a_drv && !inject_en) |=> (dir_status == 2'b10 && a_oe && !b_oe && a_out == $past(b_in))) else $error("b fwd"); // R3

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!a_drv && !b_drv && !inject_en) |=> (dir_status == 2'b00 && !a_oe && !b_oe)) else $error("release"); // R4

  AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (a_drv && b_drv) |=> (contention && dir_status == $past(dir_status))) else $error("clash"); // R5

  AST_CLASH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(a_drv && b_drv) |=> !contention) else $error("clash clear"); // R5

  AST_GLITCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (a_drv && !b_drv && inject_en && !invert_mode) |=> (b_out == '0 && b_oe)) else $error("zero"); // R6

  AST_OWNER_READBACK: assert property (@(posedge clk) disable iff (rst)
    (a_drv && !b_drv && inject_en) |=> (!a_oe && a_out == $past(a_in))) else $error("readback"); // R7

  AST_GLITCH_INVERT: assert property (@(posedge clk) disable iff (rst)
    (b_drv && !a_drv && inject_en && invert_mode) |=> (a_out == ~$past(b_in))) else $error("invert"); // R8

  AST_IDLE_GLITCH: assert property (@(posedge clk) disable iff (rst)
    (!a_drv && !b_drv && inject_en) |=> (a_oe && b_oe && a_out == '0 && b_out == '0)) else $error("idle glitch"); // R9

  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (a_oe && b_oe) |-> (dir_status == 2'b00)) else $error("dual drive"); // R9

endmodule

bind bidir_fault_injector fi_checker #(.W(W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .inject_en   (inject_en),
  .invert_mode (invert_mode),
  .a_in        (a_in),
  .a_drv       (a_drv),
  .a_out       (a_out),
  .a_oe        (a_oe),
  .b_in        (b_in),
  .b_drv       (b_drv),
  .b_out       (b_out),
  .b_oe        (b_oe),
  .dir_status  (dir_status),
  .contention  (contention)
);

// File: tb/bidir_fault_injector_tb_top.sv
module bidir_fault_injector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int NV         = 15;
  localparam int WATCHDOG   = 5000;

  // {a_drv,b_drv,inject,invert, a_in, b_in, exp_dir, exp_aoe,exp_boe,exp_cont, exp_aout, exp_bout}
  localparam logic [24:0] VEC [NV] = '{
    {4'b0000, 4'h5, 4'h3, 2'b00, 3'b000, 4'h0, 4'h0},
    {4'b1000, 4'hA, 4'h3, 2'b01, 3'b010, 4'hA, 4'hA},
    {4'b1010, 4'h6, 4'h3, 2'b01, 3'b010, 4'h6, 4'h0},
    {4'b1011, 4'h6, 4'h3, 2'b01, 3'b010, 4'h6, 4'h9},
    {4'b1100, 4'hC, 4'h3, 2'b01, 3'b011, 4'hC, 4'hC},
    {4'b0100, 4'hC, 4'h3, 2'b10, 3'b100, 4'h3, 4'h3},
    {4'b0110, 4'h0, 4'h5, 2'b10, 3'b100, 4'h0, 4'h5},
    {4'b0111, 4'h0, 4'h5, 2'b10, 3'b100, 4'hA, 4'h5},
    {4'b1100, 4'hF, 4'h5, 2'b10, 3'b101, 4'h5, 4'h5},
    {4'b0011, 4'h7, 4'h7, 2'b00, 3'b110, 4'h0, 4'h0},
    {4'b0000, 4'h7, 4'h7, 2'b00, 3'b000, 4'h0, 4'h0},
    {4'b1100, 4'h9, 4'h6, 2'b00, 3'b001, 4'h0, 4'h0},
    {4'b0100, 4'h9, 4'hE, 2'b10, 3'b100, 4'hE, 4'hE},
    {4'b1000, 4'h1, 4'hE, 2'b01, 3'b010, 4'h1, 4'h1},
    {4'b0000, 4'h1, 4'hE, 2'b00, 3'b000, 4'h0, 4'h0}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         inject_en, invert_mode;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drv, b_drv, a_oe, b_oe, contention;
  logic [1:0]   dir_status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bidir_fault_injector #(.W(W)) dut_i (
    .clk (clk), .rst (rst), .inject_en (inject_en), .invert_mode (invert_mode),
    .a_in (a_in), .a_drv (a_drv), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_drv (b_drv), .b_out (b_out), .b_oe (b_oe),
    .dir_status (dir_status), .contention (contention)
  );

  function automatic string tag_of(int i);
    case (i)
      0, 10, 14: return "R4";
      1:         return "R2";
      2, 6:      return "R6_R7";
      3, 7:      return "R8";
      4, 8, 11:  return "R5";
      5, 13:     return "R10";
      9:         return "R9";
      default:   return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [1:0] e_dir, logic e_aoe, logic e_boe,
                       logic e_cont, logic [W-1:0] e_aout, logic [W-1:0] e_bout);
    checks++;
    if (dir_status !== e_dir || a_oe !== e_aoe || b_oe !== e_boe ||
        contention !== e_cont || a_out !== e_aout || b_out !== e_bout) begin
      errors++;
      $display("FAIL %s: got dir=%b aoe=%b boe=%b cont=%b aout=%h bout=%h, expected dir=%b aoe=%b boe=%b cont=%b aout=%h bout=%h",
               tag, dir_status, a_oe, b_oe, contention, a_out, b_out,
               e_dir, e_aoe, e_boe, e_cont, e_aout, e_bout);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; inject_en = 1'b0; invert_mode = 1'b0;
    a_in = '0; b_in = '0; a_drv = 1'b0; b_drv = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state after power-up reset
    check("R1", 2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {a_drv, b_drv, inject_en, invert_mode} = VEC[i][24:21];
      a_in = VEC[i][20:17];
      b_in = VEC[i][16:13];
      @(negedge clk);
      check(tag_of(i), VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8],
            VEC[i][7:4], VEC[i][3:0]);
    end

    // R1: reset overrides live traffic with an active owner and a clash
    a_drv = 1'b1; b_drv = 1'b0; a_in = 4'hB; inject_en = 1'b0; invert_mode = 1'b0;
    @(negedge clk);
    check("R2", 2'b01, 1'b0, 1'b1, 1'b0, 4'hB, 4'hB);
    b_drv = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1", 2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    rst = 1'b0; a_drv = 1'b0; b_in = 4'h4;
    @(negedge clk);
    // R3: after reset, B alone takes the line
    check("R3", 2'b10, 1'b1, 1'b0, 1'b0, 4'h4, 4'h4);

    // R9: idle glitch with invert off also forces zero on both segments
    b_drv = 1'b0; inject_en = 1'b1;
    @(negedge clk);
    check("R9", 2'b00, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0);

    // R5: clash from idle with a glitch keeps idle and drives zero
    a_drv = 1'b1; b_drv = 1'b1; a_in = 4'hF; b_in = 4'hF;
    @(negedge clk);
    check("R5", 2'b00, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0);

    // R5: flag drops the cycle after the clash ends
    a_drv = 1'b0; b_drv = 1'b0; inject_en = 1'b0;
    @(negedge clk);
    check("R5", 2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);

    finish_run();
  end

endmodule